// File: doc/BRIEF.md
# Byte-Parallel PROM Configuration Serializer

This block is the loading master for a byte-wide configuration PROM. After a start pulse, it places an address on the PROM address bus and reads one data byte every eight clocks. It then moves the address one step in the selected direction and shifts the byte out, least significant bit first, on a single serial line. Daisy-chained devices further down the chain sample that line on their rising clock edges. The serial line only changes on falling edges. The first bit of each byte appears one and a half clock periods after the rising edge that read the byte.

A mode code selects the direction. Ascending addressing starts at zero. Descending addressing starts at the top of the enabled address space. A width option extends the address from 18 to 22 lines. The four extra lines get an output enable, which is held low while the narrow width is in use. A programmed byte count sets the length of the load. When the last bit has been presented, the block raises done and freezes the address and the serial line.

Top module: `prom_cfg_serializer`

## Requirements
- R1: With mode code 3'b100, the first byte is read from address 0 and each later byte from the previous address plus one.
- R2: With mode code 3'b110, the first byte is read from 0x3FFFF (narrow width) or 0x3FFFFF (wide width), and each later byte from the previous address minus one.
- R3: A byte is captured on a rising edge, and the address moves to its next value on that same edge.
- R4: The serial output changes only on falling edges. Bit 0 of a byte first appears on the falling edge 1.5 clock periods after the rising edge that captured it.
- R5: Each byte is sent as eight consecutive bits, bit 0 first. The next byte follows the previous one with no idle cycle.
- R6: When wide_en is low at start, the high-line enable is 0 and address bits 21:18 stay 0. When wide_en is high, the enable is 1 and bits 21:18 count together with the lower bits.
- R7: After byte_total bytes have been sent, done goes high on the rising edge after the last bit's falling edge. Address and serial output then stay unchanged until the next accepted start.
- R8: While reset is low, the serial output is 1 and done is 0. The address equals the start value that the current mode and wide_en select.
- R9: A start pulse that arrives with any mode code other than 3'b100 or 3'b110 is ignored. The address and outputs do not change.
- R10: A start with byte_total equal to 0 raises done on the same edge that loads the start address, and no byte is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a load when idle |
| mode | input | 3 | Direction code: 3'b100 ascending, 3'b110 descending |
| wide_en | input | 1 | Use 22 address lines instead of 18 |
| byte_total | input | CNT_W | Number of bytes to load |
| prom_data | input | 8 | Data byte from the PROM |
| prom_addr | output | 22 | PROM address |
| addr_hi_oe | output | 1 | Output enable for address bits 21:18 |
| ser_out | output | 1 | Serial data to the next device |
| done | output | 1 | Load finished |

## Verification
The embedded properties check, on every clock:
- that the address steps by exactly one in the latched direction at each capture;
- that the upper lines stay zero at narrow width;
- that the falling-edge output always equals the bit that the rising-edge logic prepared;
- that a new byte never loads before the previous one has finished shifting;
- that the state is frozen after done;
- that an illegal mode never starts a load.

Only the bench scenarios can show the exact bit stream against the PROM contents. They also show the 1.5-clock lag measured from the capture edge, the start addresses of both directions at both widths, the zero-length load, and the reset values.

// File: rtl/prom_cfg_serializer.sv
module prom_cfg_serializer #(
  parameter int NARROW_AW = 18,
  parameter int WIDE_AW   = 22,
  parameter int CNT_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2:0]         mode,
  input  logic               wide_en,
  input  logic [CNT_W-1:0]   byte_total,
  input  logic [7:0]         prom_data,
  output logic [WIDE_AW-1:0] prom_addr,
  output logic               addr_hi_oe,
  output logic               ser_out,
  output logic               done
);
  localparam int HI_W = WIDE_AW - NARROW_AW;
  localparam logic [2:0] MODE_UP = 3'b100;
  localparam logic [2:0] MODE_DN = 3'b110;
  localparam logic [WIDE_AW-1:0] NARROW_MASK = {{HI_W{1'b0}}, {NARROW_AW{1'b1}}};
  localparam logic [WIDE_AW-1:0] WIDE_MASK   = {WIDE_AW{1'b1}};

  logic             run, dn_q, wide_q, hold_full, tx_bit;
  logic [2:0]       ph, bits_left;
  logic [CNT_W-1:0] cap_left;
  logic [7:0]       hold;
  logic [6:0]       shreg;

  wire mode_ok = (mode == MODE_UP) || (mode == MODE_DN);
  wire in_down = (mode == MODE_DN);
  wire [WIDE_AW-1:0] in_mask  = wide_en ? WIDE_MASK : NARROW_MASK;
  wire [WIDE_AW-1:0] in_start = in_down ? in_mask : '0;
  wire [WIDE_AW-1:0] cur_mask = wide_q ? WIDE_MASK : NARROW_MASK;
  wire [WIDE_AW-1:0] addr_step =
    (dn_q ? prom_addr - 1'b1 : prom_addr + 1'b1) & cur_mask;

  wire cap    = run && (ph == 3'd0) && (cap_left != '0);
  wire load   = run && (ph == 3'd1) && hold_full;
  wire finish = run && (ph == 3'd1) && !hold_full && (cap_left == '0) && (bits_left == 3'd0);

  assign addr_hi_oe = wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prom_addr <= in_start;
      dn_q      <= in_down;
      wide_q    <= wide_en;
      run       <= 1'b0;
      done      <= 1'b0;
      ph        <= 3'd0;
      cap_left  <= '0;
      hold      <= 8'h00;
      hold_full <= 1'b0;
      shreg     <= 7'h00;
      bits_left <= 3'd0;
      tx_bit    <= 1'b1;
    end else if (!run) begin
      if (start && mode_ok) begin
        prom_addr <= in_start;
        dn_q      <= in_down;
        wide_q    <= wide_en;
        ph        <= 3'd0;
        cap_left  <= byte_total;
        hold_full <= 1'b0;
        bits_left <= 3'd0;
        run       <= (byte_total != '0);
        done      <= (byte_total == '0);
      end
    end else begin
      ph <= ph + 3'd1;
      if (cap) begin
        hold      <= prom_data;
        hold_full <= 1'b1;
        cap_left  <= cap_left - 1'b1;
        prom_addr <= addr_step;
      end
      if (load) begin
        tx_bit    <= hold[0];
        shreg     <= hold[7:1];
        bits_left <= 3'd7;
        hold_full <= 1'b0;
      end else if (bits_left != 3'd0) begin
        tx_bit    <= shreg[0];
        shreg     <= {1'b0, shreg[6:1]};
        bits_left <= bits_left - 3'd1;
      end
      if (finish) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_ff @(negedge clk) begin
    if (!rst_n) ser_out <= 1'b1;
    else        ser_out <= tx_bit;
  end

  assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && !dn_q) |=> prom_addr == (($past(prom_addr) + 1'b1) & $past(cur_mask)));

  assert_dn_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && dn_q) |=> prom_addr == (($past(prom_addr) - 1'b1) & $past(cur_mask)));

  assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ser_out == tx_bit);

  assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> bits_left == 3'd0);

  assert_hi_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hi_oe |-> prom_addr[WIDE_AW-1:NARROW_AW] == '0);

  assert_hold_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(prom_addr) && $stable(tx_bit) && done));

  assert_bad_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && start && !mode_ok) |=> (!run && $stable(prom_addr)));
endmodule

// File: tb/tb_prom_cfg_serializer.sv
module tb_prom_cfg_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'b110;
  logic        wide_en = 1'b0;
  logic [15:0] byte_total = 16'd0;
  logic [7:0]  prom_data;
  logic [21:0] prom_addr;
  logic        addr_hi_oe, ser_out, done;

  int n_cmp = 0;
  int n_bad = 0;
  logic prev_sd;

  always #4 clk = ~clk;

  function automatic logic [7:0] prom_byte(input logic [21:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5C ^ {6'b0, a[21:20]};
  endfunction

  assign prom_data = prom_byte(prom_addr);

  prom_cfg_serializer dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .wide_en(wide_en),
    .byte_total(byte_total), .prom_data(prom_data), .prom_addr(prom_addr),
    .addr_hi_oe(addr_hi_oe), .ser_out(ser_out), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {mode[2:0], wide, count[7:0]}
  localparam logic [11:0] VEC [0:5] = '{
    {3'b100, 1'b0, 8'd4},
    {3'b110, 1'b0, 8'd5},
    {3'b100, 1'b1, 8'd3},
    {3'b110, 1'b1, 8'd2},
    {3'b100, 1'b0, 8'd1},
    {3'b110, 1'b0, 8'd3}
  };

  task automatic run_case(input logic [2:0] m, input logic w, input int n);
    logic [21:0] mask, s0, a;
    logic [7:0]  b;
    bit dn;
    dn   = (m == 3'b110);
    mask = w ? 22'h3FFFFF : 22'h03FFFF;
    s0   = dn ? mask : 22'h0;
    @(negedge clk);
    mode = m; wide_en = w; byte_total = 16'(n); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk); #1;
    chk("R3 address stepped on capture edge", prom_addr, dn ? (s0 - 22'd1) & mask : 22'd1);
    chk("R6 high-line enable", addr_hi_oe, w);
    chk("R4 no early bit after capture", ser_out, prev_sd);
    @(posedge clk); #1;
    chk("R4 output unchanged at rising edge", ser_out, prev_sd);
    for (int k = 0; k < n; k++) begin
      a = dn ? (s0 - 22'(k)) & mask : (s0 + 22'(k)) & mask;
      b = prom_byte(a);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk); #1;
        chk(dn ? "R5 R2 serial bit" : "R5 R1 serial bit", ser_out, b[j]);
        if (j == 0) chk("R7 done low during load", done, 1'b0);
        prev_sd = b[j];
      end
    end
    @(posedge clk); #1;
    chk("R7 done after last bit", done, 1'b1);
    a = dn ? (s0 - 22'(n)) & mask : (s0 + 22'(n)) & mask;
    chk(dn ? "R2 final address" : "R1 final address", prom_addr, a);
    if (!w) chk("R6 upper lines quiet", prom_addr[21:18], 4'h0);
    repeat (10) @(posedge clk);
    #1;
    chk("R7 address held", prom_addr, a);
    chk("R7 serial held", ser_out, prev_sd);
    chk("R7 done held", done, 1'b1);
  endtask

  initial begin
    prev_sd = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset address", prom_addr, 22'h03FFFF);
    chk("R8 reset serial high", ser_out, 1'b1);
    chk("R8 reset done low", done, 1'b0);
    chk("R8 reset high-line enable", addr_hi_oe, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    @(negedge clk);
    mode = 3'b000; byte_total = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (12) @(posedge clk);
    #1;
    chk("R9 bad mode address", prom_addr, 22'h03FFFF);
    chk("R9 bad mode done", done, 1'b0);
    chk("R9 bad mode serial", ser_out, 1'b1);

    @(negedge clk);
    mode = 3'b100; wide_en = 1'b0; byte_total = 16'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 zero count done", done, 1'b1);
    chk("R10 zero count address", prom_addr, 22'h0);
    @(posedge clk); #1;
    chk("R10 no capture", prom_addr, 22'h0);

    for (int v = 0; v < 6; v++)
      run_case(VEC[v][11:9], VEC[v][8], int'(VEC[v][7:0]));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule